// File: doc/BRIEF.md
# Next Fetch Address Unit

This block owns the 32-bit program counter of a simple in-order core and works out, from the instruction currently being fetched and the two operand values read for it, where the next fetch goes. It covers plain sequential flow, two register-compare conditional branches (equal and not equal), an absolute jump inside the current 256 MiB region, a jump that also saves a return address, and a jump through a register. Branches take effect on the next clock edge. There are no delay slots.

The core presents the instruction word and the two register read values each cycle. The unit answers with the current PC. For the linking jump, it also raises a write request carrying the return address, which the register file stores in register 31. A hold input freezes the PC and suppresses that write. A register-indirect target whose two low bits are not zero is flagged in the same cycle so that surrounding logic can act on it. The unit still loads such a target unchanged.

Top module: `npc_unit`

## Requirements
- R1: While reset is high at a clock edge, the PC loads START_ADDR (default 0x0040_0000).
- R2: An instruction that is not a branch or jump advances the PC by 4 on the next edge. This includes opcode 0 (bits 31:26) with any function code (bits 5:0) other than 0x08.
- R3: Opcode 4 with equal rs and rt values loads PC+4 plus the sign-extended 16-bit immediate (bits 15:0) times 4. With unequal values the PC advances by 4.
- R4: Opcode 5 with unequal rs and rt values loads the same branch target as R3. With equal values the PC advances by 4.
- R5: A negative immediate produces a backward branch target, so the sign extension covers all 32 bits.
- R6: Opcode 2 loads a target made from the top four bits of PC+4, then bits 25:0 of the instruction, then two zero bits.
- R7: Opcode 3 loads the same target as R6. In the same cycle it raises link_we_o with link_data_o equal to PC+8.
- R8: Opcode 0 with function code 0x08 loads the PC with the rs value unchanged.
- R9: misalign_o is high in the cycle of an R8 instruction whose rs value has a non-zero bit 1 or bit 0. In every other case it is low.
- R10: While stall_i is high the PC keeps its value and link_we_o stays low.
- R11: link_we_o is low for every instruction other than opcode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Hold the PC and suppress the link write |
| instr_i | input | 32 | Instruction at the current PC |
| rs_val_i | input | 32 | Value of the first source register |
| rt_val_i | input | 32 | Value of the second source register |
| pc_o | output | 32 | Current program counter |
| link_we_o | output | 1 | Request to write the return address to register 31 |
| link_data_o | output | 32 | Return address, PC+8 |
| misalign_o | output | 1 | Register-indirect target not word aligned |

## Verification
The hardest case to reach from the ports is the top four bits of the absolute jump target. From the reset address those bits are zero, so an error in them stays hidden. The stimulus first uses a register-indirect jump to move the PC into the region 0x8xxx_xxxx and then issues an absolute jump with an all-ones address field. The expected result only comes out right if the region bits of PC+4 are kept. Stalls are placed on a linking jump and on a taken branch, so the bench can check that both the hold and the suppressed write win over a redirect.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int WORD_W     = 32;
    localparam int INSTR_BYTES = 4;

    localparam logic [5:0] OP_SPECIAL = 6'd0;
    localparam logic [5:0] OP_JUMP    = 6'd2;
    localparam logic [5:0] OP_JLINK   = 6'd3;
    localparam logic [5:0] OP_BREQ    = 6'd4;
    localparam logic [5:0] OP_BRNE    = 6'd5;
    localparam logic [5:0] FN_REGJMP  = 6'h08;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_BREQ,
        FLOW_BRNE,
        FLOW_JUMP,
        FLOW_JLINK,
        FLOW_REGJMP
    } flow_e;

    typedef struct packed {
        flow_e       flow;
        logic [15:0] offset;
        logic [25:0] region_idx;
    } decoded_t;

    function automatic logic [WORD_W-1:0] branch_dest(
        input logic [WORD_W-1:0] seq_pc,
        input logic [15:0]       offset
    );
        logic [WORD_W-1:0] wide;
        wide = {{(WORD_W-16){offset[15]}}, offset};
        return seq_pc + (wide << 2);
    endfunction

    function automatic logic [WORD_W-1:0] region_dest(
        input logic [WORD_W-1:0] seq_pc,
        input logic [25:0]       idx
    );
        return {seq_pc[WORD_W-1:WORD_W-4], idx, 2'b00};
    endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [WORD_W-1:0] instr_i,
    output decoded_t          dec_o
);
    logic [5:0] opcode;
    logic [5:0] funct;

    assign opcode = instr_i[31:26];
    assign funct  = instr_i[5:0];

    always_comb begin
        dec_o.offset     = instr_i[15:0];
        dec_o.region_idx = instr_i[25:0];
        unique case (opcode)
            OP_BREQ:    dec_o.flow = FLOW_BREQ;
            OP_BRNE:    dec_o.flow = FLOW_BRNE;
            OP_JUMP:    dec_o.flow = FLOW_JUMP;
            OP_JLINK:   dec_o.flow = FLOW_JLINK;
            OP_SPECIAL: dec_o.flow = (funct == FN_REGJMP) ? FLOW_REGJMP : FLOW_SEQ;
            default:    dec_o.flow = FLOW_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
(
    input  decoded_t          dec_i,
    input  logic [WORD_W-1:0] pc_i,
    input  logic [WORD_W-1:0] rs_val_i,
    input  logic [WORD_W-1:0] rt_val_i,
    input  logic              stall_i,
    output logic [WORD_W-1:0] next_pc_o,
    output logic              link_we_o,
    output logic [WORD_W-1:0] link_data_o,
    output logic              misalign_o
);
    logic [WORD_W-1:0] seq_pc;
    logic [WORD_W-1:0] br_pc;
    logic              same;

    assign seq_pc = pc_i + WORD_W'(INSTR_BYTES);
    assign br_pc  = branch_dest(seq_pc, dec_i.offset);
    assign same   = (rs_val_i == rt_val_i);

    always_comb begin
        case (dec_i.flow)
            FLOW_BREQ:   next_pc_o = same ? br_pc : seq_pc;
            FLOW_BRNE:   next_pc_o = same ? seq_pc : br_pc;
            FLOW_JUMP,
            FLOW_JLINK:  next_pc_o = region_dest(seq_pc, dec_i.region_idx);
            FLOW_REGJMP: next_pc_o = rs_val_i;
            default:     next_pc_o = seq_pc;
        endcase
    end

    assign link_data_o = pc_i + WORD_W'(2 * INSTR_BYTES);
    assign link_we_o   = (dec_i.flow == FLOW_JLINK) && !stall_i;
    assign misalign_o  = (dec_i.flow == FLOW_REGJMP) && (rs_val_i[1:0] != 2'b00);
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg
    import npc_pkg::*;
#(
    parameter logic [WORD_W-1:0] START_ADDR = 32'h0040_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_i,
    input  logic [WORD_W-1:0] next_pc_i,
    output logic [WORD_W-1:0] pc_o
);
    always_ff @(posedge clk) begin
        if (rst)
            pc_o <= START_ADDR;
        else if (!hold_i)
            pc_o <= next_pc_i;
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] START_ADDR = 32'h0040_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        stall_i,
    input  logic [31:0] instr_i,
    input  logic [31:0] rs_val_i,
    input  logic [31:0] rt_val_i,
    output logic [31:0] pc_o,
    output logic        link_we_o,
    output logic [31:0] link_data_o,
    output logic        misalign_o
);
    decoded_t          dec;
    logic [WORD_W-1:0] next_pc;

    npc_decode u_dec (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    npc_select u_sel (
        .dec_i       (dec),
        .pc_i        (pc_o),
        .rs_val_i    (rs_val_i),
        .rt_val_i    (rt_val_i),
        .stall_i     (stall_i),
        .next_pc_o   (next_pc),
        .link_we_o   (link_we_o),
        .link_data_o (link_data_o),
        .misalign_o  (misalign_o)
    );

    npc_pc_reg #(.START_ADDR(START_ADDR)) u_pc (
        .clk       (clk),
        .rst       (rst),
        .hold_i    (stall_i),
        .next_pc_i (next_pc),
        .pc_o      (pc_o)
    );
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter logic [31:0] START_ADDR = 32'h0040_0000
) (
    input logic        clk,
    input logic        rst,
    input logic        stall_i,
    input logic [31:0] instr_i,
    input logic [31:0] rs_val_i,
    input logic [31:0] pc_o,
    input logic        link_we_o,
    input logic [31:0] link_data_o,
    input logic        misalign_o
);
    logic [5:0] op;
    logic       is_regjmp;
    logic       is_plain;

    assign op        = instr_i[31:26];
    assign is_regjmp = (op == 6'd0) && (instr_i[5:0] == 6'h08);
    assign is_plain  = (op == 6'd1) || (op > 6'd5) || ((op == 6'd0) && !is_regjmp);

    AST_RESET_START: assert property (@(posedge clk) $fell(rst) |-> pc_o == START_ADDR); // R1

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && is_plain) |=> pc_o == $past(pc_o) + 32'd4); // R2

    AST_LINK_VALUE: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && op == 6'd3) |-> (link_we_o && link_data_o == pc_o + 32'd8)); // R7

    AST_REGJMP_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && is_regjmp) |=> pc_o == $past(rs_val_i)); // R8

    AST_MISALIGN_SRC: assert property (@(posedge clk) disable iff (rst)
        misalign_o |-> is_regjmp); // R9

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> $stable(pc_o)); // R10

    AST_LINK_ONLY_JAL: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> (op == 6'd3 && !stall_i)); // R11
endmodule

bind npc_unit npc_unit_chk #(.START_ADDR(START_ADDR)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .stall_i     (stall_i),
    .instr_i     (instr_i),
    .rs_val_i    (rs_val_i),
    .pc_o        (pc_o),
    .link_we_o   (link_we_o),
    .link_data_o (link_data_o),
    .misalign_o  (misalign_o)
);

// File: tb/npc_unit_tb_top.sv
module npc_unit_tb_top;

    localparam logic [31:0] START = 32'h0040_0000;

    typedef struct packed {
        logic [31:0] instr;
        logic [31:0] rs;
        logic [31:0] rt;
        logic        stall;
        logic        exp_we;
        logic        exp_mis;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 32'h1, 32'h2, 1'b0, 1'b0, 1'b0},                          // R2 funct 0
        '{32'h0085_1020, 32'h7, 32'h7, 1'b0, 1'b0, 1'b0},                          // R2 add
        '{{6'd4, 5'd1, 5'd2, 16'h0003}, 32'h5, 32'h5, 1'b0, 1'b0, 1'b0},           // R3 taken
        '{{6'd4, 5'd1, 5'd2, 16'h0003}, 32'h5, 32'h6, 1'b0, 1'b0, 1'b0},           // R3 not taken
        '{{6'd5, 5'd1, 5'd2, 16'hFFFE}, 32'h1, 32'h9, 1'b0, 1'b0, 1'b0},           // R4 R5 backward
        '{{6'd5, 5'd1, 5'd2, 16'h0010}, 32'h9, 32'h9, 1'b0, 1'b0, 1'b0},           // R4 not taken
        '{{6'd2, 26'h010_0040}, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0},                   // R6
        '{{6'd3, 26'h010_0080}, 32'h0, 32'h0, 1'b0, 1'b1, 1'b0},                   // R7
        '{{6'd3, 26'h000_0100}, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0},                   // R10 stalled jal
        '{{6'd0, 5'd4, 15'd0, 6'h08}, 32'h0040_0100, 32'h0, 1'b0, 1'b0, 1'b0},     // R8
        '{{6'd0, 5'd4, 15'd0, 6'h08}, 32'h0040_0102, 32'h0, 1'b0, 1'b0, 1'b1},     // R9
        '{{6'h23, 5'd1, 5'd2, 16'h0004}, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0},          // R2 load
        '{{6'd4, 5'd1, 5'd2, 16'h0040}, 32'h3, 32'h3, 1'b1, 1'b0, 1'b0},           // R10 stalled branch
        '{{6'd0, 5'd4, 15'd0, 6'h09}, 32'h0000_1000, 32'h0, 1'b0, 1'b0, 1'b0}      // R2 R8 funct 9
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] rs_val_i = '0;
    logic [31:0] rt_val_i = '0;
    logic [31:0] pc_o;
    logic        link_we_o;
    logic [31:0] link_data_o;
    logic        misalign_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    npc_unit #(.START_ADDR(START)) dut_i (
        .clk(clk), .rst(rst), .stall_i(stall_i), .instr_i(instr_i),
        .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .pc_o(pc_o),
        .link_we_o(link_we_o), .link_data_o(link_data_o), .misalign_o(misalign_o)
    );

    function automatic logic [31:0] ref_next(input logic [31:0] pc, input logic [31:0] ins,
                                             input logic [31:0] rs, input logic [31:0] rt,
                                             input logic st);
        logic [31:0] off;
        off = 32'($signed(ins[15:0])) * 32'd4;
        if (st) return pc;
        case (ins[31:26])
            6'd4: return (rs == rt) ? pc + 32'd4 + off : pc + 32'd4;
            6'd5: return (rs != rt) ? pc + 32'd4 + off : pc + 32'd4;
            6'd2, 6'd3: return ((pc + 32'd4) & 32'hF000_0000) | (32'(ins[25:0]) * 32'd4);
            6'd0: return (ins[5:0] == 6'h08) ? rs : pc + 32'd4;
            default: return pc + 32'd4;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic [31:0] ins, input logic [31:0] rs, input logic [31:0] rt,
                        input logic st, input logic ewe, input logic emis, input string req);
        logic [31:0] exp_pc;
        @(negedge clk);
        instr_i = ins; rs_val_i = rs; rt_val_i = rt; stall_i = st;
        #1;
        exp_pc = ref_next(pc_o, ins, rs, rt, st);
        check({req, " link_we"}, 32'(link_we_o), 32'(ewe));
        check({req, " misalign"}, 32'(misalign_o), 32'(emis));
        if (ewe) check({req, " link_data"}, link_data_o, pc_o + 32'd8);
        @(posedge clk);
        #1;
        check({req, " pc"}, pc_o, exp_pc);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset pc", pc_o, START);
        rst = 1'b0;

        for (int i = 0; i < NV; i++)
            step(VECS[i].instr, VECS[i].rs, VECS[i].rt, VECS[i].stall,
                 VECS[i].exp_we, VECS[i].exp_mis, "R2-table");

        // R6 region bits: move to upper region, then absolute jump keeps them
        step({6'd0, 5'd4, 15'd0, 6'h08}, 32'h8000_0010, 32'h0, 1'b0, 1'b0, 1'b0, "R8 far");
        step({6'd2, 26'h3FF_FFFF}, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, "R6 region");
        check("R6 region value", pc_o, 32'h8FFF_FFFC);

        // R5 large negative offset
        step({6'd4, 5'd0, 5'd0, 16'h8000}, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, "R5 min offset");
        // R3 zero offset
        step({6'd4, 5'd0, 5'd0, 16'h0000}, 32'h4, 32'h4, 1'b0, 1'b0, 1'b0, "R3 zero offset");
        // R9 low bit only
        step({6'd0, 5'd4, 15'd0, 6'h08}, 32'h0040_0201, 32'h0, 1'b0, 1'b0, 1'b1, "R9 bit0");
        // R11 branch not raising link
        step({6'd5, 5'd1, 5'd2, 16'h0001}, 32'h1, 32'h2, 1'b0, 1'b0, 1'b0, "R11 bne");

        // R1 reset in mid run
        @(negedge clk);
        rst = 1'b1; stall_i = 1'b0; instr_i = '0;
        @(posedge clk);
        #1;
        check("R1 mid reset", pc_o, START);
        @(negedge clk);
        rst = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule